// File: doc/BRIEF.md
# Receive Sample Delay Aligner

This block sits in the receive path of a serial flash master. It corrects for the round-trip delay between the master's serial clock and the data that the flash device returns. The transfer engine raises a bit request on each serial rising edge that carries a bit. The aligner does not capture the lanes at that edge. It moves the capture point later by a programmable whole number of serial clock periods, from 0 to 7. It captures on either the rising or the falling serial edge at that point.

Each capture produces a one-cycle valid strobe and the captured lane bits, and these feed the engine's shift registers. The strobe is delayed by the same amount as the data, so a transfer yields exactly as many strobes as bit requests. A busy output stays high while any delayed sample is still outstanding. The engine holds slave select and the serial clock running until busy drops. The output is a plain valid strobe with no ready: the serial line cannot be paused, so no back-pressure is accepted, and the consumer must take each beat in the cycle that it is valid. All timing is in system clocks. The serial edges arrive as one-cycle pulses, and a rising pulse and a falling pulse never fall in the same cycle. The configuration must only change while busy is low.

Top module: `rx_sample_aligner`

## Requirements
- R1: While reset is asserted and after it is released, out_valid, out_bits and pipe_busy are all 0.
- R2: A bit request seen with sclk_rise is sampled at the rising edge that comes cfg_dly serial periods later. With cfg_dly = 0 that is the same rising edge. out_valid and out_bits appear one system clock after the sampling cycle.
- R3: With cfg_fall = 0, sampling happens in the sclk_rise cycle that R2 selects.
- R4: With cfg_fall = 1, sampling happens in the first sclk_fall cycle after the rising edge that R2 selects.
- R5: Every bit request produces exactly one out_valid pulse, and the pulses keep the order of the requests.
- R6: cfg_lanes selects the active lanes: 0 is one lane (bit 0), 1 is two lanes (bits 1:0), 2 and 3 are four lanes (bits 3:0). Inactive lanes always read 0 on out_bits, whatever level is on their input.
- R7: pipe_busy is high in every cycle in which an accepted request has not yet been sampled. It drops in the same cycle that the last strobe appears.
- R8: Suppose the device returns each bit one serial period after its request and the idle line is high. With cfg_dly = 0 and a one-lane read of 0xEF, the assembled byte is 0xF7. With cfg_dly = 1 it is 0xEF.
- R9: With cfg_dly = 0 and cfg_fall = 0, pipe_busy never rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_dly | input | DLY_W | Delay of the capture point, in whole serial periods |
| cfg_fall | input | 1 | Capture edge: 0 rising, 1 falling |
| cfg_lanes | input | 2 | Lane count select |
| sclk_rise | input | 1 | One-cycle pulse at each serial rising edge |
| sclk_fall | input | 1 | One-cycle pulse at each serial falling edge |
| bit_req | input | 1 | The current rising edge carries a bit to be received |
| rx_lanes | input | LANES | Data lines returned by the device |
| out_valid | output | 1 | One-cycle strobe for a captured beat |
| out_bits | output | LANES | Captured lane bits, held until the next capture |
| pipe_busy | output | 1 | Delayed samples are still outstanding |

## Verification
A modelled device returns data with a fixed latency. The latency is a whole number of serial periods for rising capture, and a period and a half for falling capture. Sweeping delay and edge against that latency tells a correct alignment apart from one that is a period early. The early case yields the right-shifted 0xF7 pattern, both for a short delay and for a rising capture of half-period-late data. The 2-lane and 4-lane runs drive the unused lanes high, which tells lane masking apart from raw pass-through. A zero-latency run checks the undelayed path and the absence of busy.

// File: rtl/rxa_pkg.sv
package rxa_pkg;

  typedef enum logic [1:0] {
    LN_ONE   = 2'd0,
    LN_TWO   = 2'd1,
    LN_FOUR  = 2'd2,
    LN_FOURX = 2'd3
  } lane_mode_e;

  // Number of lanes the mode activates.
  function automatic int lane_count(input logic [1:0] mode);
    case (lane_mode_e'(mode))
      LN_ONE:  return 1;
      LN_TWO:  return 2;
      default: return 4;
    endcase
  endfunction

endpackage

// File: rtl/rxa_tok_line.sv
// Token delay line: one stage per serial period. A token leaves the line
// at the stage picked by sel, so no stale token lingers past the tap.
module rxa_tok_line #(
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             req,
  input  logic [DLY_W-1:0] sel,
  output logic             hit,
  output logic             pending
);
  localparam int STAGES = (1 << DLY_W) - 1;

  logic [STAGES:1] tok;
  logic [STAGES:1] tok_nxt;
  logic [STAGES:0] tap;

  assign tap = {tok, req};
  assign hit = tap[sel];

  always_comb begin
    for (int k = 1; k <= STAGES; k++) begin
      tok_nxt[k] = tap[k-1] && (int'(sel) != k - 1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   tok <= '0;
    else if (adv) tok <= tok_nxt;
  end

  assign pending = |tok;
endmodule

// File: rtl/rxa_edge_sel.sv
// Chooses the capture edge: the delayed rising edge itself, or the first
// falling edge after it.
module rxa_edge_sel (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_hit,
  input  logic sclk_fall,
  input  logic use_fall,
  output logic cap,
  output logic pend
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                    pend <= 1'b0;
    else if (use_fall && rise_hit) pend <= 1'b1;
    else if (sclk_fall)            pend <= 1'b0;
  end

  assign cap = use_fall ? (sclk_fall && pend) : rise_hit;
endmodule

// File: rtl/rxa_lane_cap.sv
// Capture flop for a single lane.
module rxa_lane_cap (
  input  logic clk,
  input  logic rst_n,
  input  logic cap,
  input  logic en,
  input  logic din,
  output logic q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   q <= 1'b0;
    else if (cap) q <= din && en;
  end
endmodule

// File: rtl/rx_sample_aligner.sv
module rx_sample_aligner
  import rxa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DLY_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [DLY_W-1:0] cfg_dly,
  input  logic             cfg_fall,
  input  logic [1:0]       cfg_lanes,
  input  logic             sclk_rise,
  input  logic             sclk_fall,
  input  logic             bit_req,
  input  logic [LANES-1:0] rx_lanes,
  output logic             out_valid,
  output logic [LANES-1:0] out_bits,
  output logic             pipe_busy
);
  logic hit;
  logic tok_pend;
  logic rise_hit;
  logic cap;
  logic fall_pend;
  logic [LANES-1:0] lane_en;

  rxa_tok_line #(.DLY_W(DLY_W)) u_line (
    .clk     (clk),
    .rst_n   (rst_n),
    .adv     (sclk_rise),
    .req     (bit_req && sclk_rise),
    .sel     (cfg_dly),
    .hit     (hit),
    .pending (tok_pend)
  );

  assign rise_hit = sclk_rise && hit;

  rxa_edge_sel u_edge (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_hit  (rise_hit),
    .sclk_fall (sclk_fall),
    .use_fall  (cfg_fall),
    .cap       (cap),
    .pend      (fall_pend)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_valid <= 1'b0;
    else        out_valid <= cap;
  end

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_en[i] = (i < lane_count(cfg_lanes));
    rxa_lane_cap u_cap (
      .clk   (clk),
      .rst_n (rst_n),
      .cap   (cap),
      .en    (lane_en[i]),
      .din   (rx_lanes[i]),
      .q     (out_bits[i])
    );
  end

  assign pipe_busy = tok_pend || fall_pend;
endmodule

// File: rtl/rxa_checker.sv
module rxa_checker
  import rxa_pkg::*;
#(
  parameter int LANES = 4,
  parameter int DLY_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [DLY_W-1:0] cfg_dly,
  input logic             cfg_fall,
  input logic [1:0]       cfg_lanes,
  input logic             sclk_rise,
  input logic             sclk_fall,
  input logic             bit_req,
  input logic [LANES-1:0] rx_lanes,
  input logic             out_valid,
  input logic [LANES-1:0] out_bits,
  input logic             pipe_busy
);
  logic [LANES-1:0] act_mask;

  always_comb begin
    for (int i = 0; i < LANES; i++) act_mask[i] = (i < lane_count(cfg_lanes));
  end

  p_lane_mask_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> ((out_bits & ~act_mask) == '0));

  p_rise_edge_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !cfg_fall) |-> $past(sclk_rise));

  p_fall_edge_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && cfg_fall) |-> $past(sclk_fall));

  p_drain_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(pipe_busy) |-> out_valid);

  p_no_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_dly == '0 && !cfg_fall && $past(cfg_dly) == '0 && !$past(cfg_fall)) |-> !pipe_busy);

  p_zero_lat_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (sclk_rise && bit_req && cfg_dly == '0 && !cfg_fall) |=> out_valid);

  p_reset_r1: assert property (@(posedge clk)
    !rst_n |=> (!out_valid && !pipe_busy));
endmodule

bind rx_sample_aligner rxa_checker #(.LANES(LANES), .DLY_W(DLY_W)) u_chk (.*);

// File: tb/sim_rx_sample_aligner.sv
module sim_rx_sample_aligner;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cfg_dly = '0;
  logic       cfg_fall = 1'b0;
  logic [1:0] cfg_lanes = '0;
  logic       sclk_rise = 1'b0;
  logic       sclk_fall = 1'b0;
  logic       bit_req = 1'b0;
  logic [3:0] rx = 4'hF;
  logic       out_valid;
  logic [3:0] out_bits;
  logic       pipe_busy;

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // stimulus state
  int lat = 0;
  int nb = 0;
  int bi = 0;
  logic [15:0] xd = '0;
  int fl_start[$];
  logic [3:0] fl_val[$];

  // collection
  logic [15:0] asm_v = '0;
  int got = 0;
  bit seen_busy = 0;

  // reference model state
  int rc = 0;
  int tq[$];
  bit m_pend = 0;
  bit m_valid = 0;
  logic [3:0] m_data = '0;
  bit m_busy = 0;

  rx_sample_aligner u0 (
    .clk(clk), .rst_n(rst_n), .cfg_dly(cfg_dly), .cfg_fall(cfg_fall),
    .cfg_lanes(cfg_lanes), .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
    .bit_req(bit_req), .rx_lanes(rx), .out_valid(out_valid),
    .out_bits(out_bits), .pipe_busy(pipe_busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [3:0] mask_of(input logic [1:0] m);
    return (m == 2'd0) ? 4'h1 : (m == 2'd1) ? 4'h3 : 4'hF;
  endfunction

  function automatic int width_of(input logic [1:0] m);
    return (m == 2'd0) ? 1 : (m == 2'd1) ? 2 : 4;
  endfunction

  always @(posedge clk) cyc <= cyc + 1;

  // Serial edge generator and modelled device (driven away from posedge)
  always @(negedge clk) begin
    int now;
    logic [3:0] chunk;
    now = cyc + 1;
    sclk_rise = rst_n && (now % 4 == 0);
    sclk_fall = rst_n && (now % 4 == 2);
    bit_req = 1'b0;
    if (sclk_rise && bi < nb) begin
      chunk = 4'((xd >> ((nb - 1 - bi) * width_of(cfg_lanes)))) & mask_of(cfg_lanes);
      bit_req = 1'b1;
      fl_start.push_back(now + lat);
      fl_val.push_back(chunk | ~mask_of(cfg_lanes));
      bi = bi + 1;
    end
    rx = 4'hF;
    foreach (fl_start[i]) begin
      if (now >= fl_start[i] && now < fl_start[i] + 4) rx = fl_val[i];
    end
  end

  // Behavioural reference: queue of target rising-edge indices
  always @(posedge clk) begin
    bit ev;
    logic [3:0] ed;
    ev = 0;
    ed = '0;
    if (!rst_n) begin
      tq.delete();
      m_pend = 0;
      m_data = '0;
      rc = 0;
    end else begin
      if (sclk_rise) begin
        if (bit_req) tq.push_back(rc + int'(cfg_dly));
        if (tq.size() > 0 && tq[0] == rc) begin
          void'(tq.pop_front());
          if (!cfg_fall) begin ev = 1; ed = rx & mask_of(cfg_lanes); end
          else m_pend = 1;
        end
        rc = rc + 1;
      end
      if (sclk_fall && m_pend) begin
        m_pend = 0;
        ev = 1;
        ed = rx & mask_of(cfg_lanes);
      end
      if (ev) m_data = ed;
    end
    m_valid = ev;
    m_busy = (tq.size() > 0) || m_pend;
  end

  // Per-cycle comparison and beat collection
  always @(negedge clk) begin
    checks++;
    if (out_valid !== m_valid || out_bits !== m_data || pipe_busy !== m_busy) begin
      fails++;
      $display("FAIL R2/R5/R7 cycle %0d: valid=%b bits=%h busy=%b expected valid=%b bits=%h busy=%b",
               cyc, out_valid, out_bits, pipe_busy, m_valid, m_data, m_busy);
    end
    if (pipe_busy) seen_busy = 1;
    if (out_valid) begin
      asm_v = (asm_v << width_of(cfg_lanes)) | 16'(out_bits & mask_of(cfg_lanes));
      got = got + 1;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic run(input int d, input bit f, input logic [1:0] ln, input int l,
                     input int n, input logic [15:0] data, input logic [15:0] exp,
                     input string req);
    @(negedge clk);
    cfg_dly = 3'(d);
    cfg_fall = f;
    cfg_lanes = ln;
    @(posedge clk);
    lat = l;
    xd = data;
    asm_v = '0;
    got = 0;
    seen_busy = 0;
    bi = 0;
    nb = n;
    do begin
      @(posedge clk);
      #1;
    end while (!(bi == n && got == n && !pipe_busy));
    repeat (40) @(posedge clk);
    check(asm_v == exp, req, asm_v, exp);
    check(got == n, "R5 strobe count", got, n);
    check(seen_busy == (d > 0 || f), "R7/R9 busy seen", seen_busy, (d > 0 || f));
    fl_start.delete();
    fl_val.delete();
  endtask

  // Watchdog
  always @(posedge clk) begin
    if (cyc > 100000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual cycle %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0, "R1 valid in reset", out_valid, 0);
    check(out_bits == 0, "R1 bits in reset", out_bits, 0);
    check(pipe_busy == 0, "R1 busy in reset", pipe_busy, 0);
    rst_n = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(out_valid == 0 && pipe_busy == 0, "R1 after release", {out_valid, pipe_busy}, 0);

    run(1, 0, 2'd0, 4, 8, 16'h00EF, 16'h00EF, "R2 R3 delay 1 rising");
    run(0, 0, 2'd0, 4, 8, 16'h00EF, 16'h00F7, "R8 delay too small");
    run(1, 1, 2'd0, 6, 8, 16'h00EF, 16'h00EF, "R4 falling capture");
    run(1, 0, 2'd0, 6, 8, 16'h00EF, 16'h00F7, "R4 rising on half-period data");
    run(7, 0, 2'd0, 28, 8, 16'h00A5, 16'h00A5, "R2 max delay");
    run(3, 1, 2'd0, 14, 8, 16'h005A, 16'h005A, "R4 delay 3 falling");
    run(2, 0, 2'd2, 8, 4, 16'h3C5A, 16'h3C5A, "R6 four lanes");
    run(0, 0, 2'd1, 0, 4, 16'h00B4, 16'h00B4, "R6 R9 two lanes no delay");
    run(4, 1, 2'd3, 18, 2, 16'h009C, 16'h009C, "R6 mode 3 as four lanes");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule